// File: doc/BRIEF.md
# Dual-Clock FIFO Reset Sequencer and Flag Initializer

This block brings a two-clock FIFO out of reset in a defined way. An active-low reset pin is sampled separately in the write-side clock domain (A) and the read-side clock domain (B). Each copy passes through a short flip-flop synchronizer. Each domain then counts the rising edges of its own clock while it sees reset asserted. A reset counts as complete only when both domains have counted four edges.

While reset is low, the status flags of each side hold their defined start values. These flags are the full, almost-full and mailbox-full flags on side A, and the empty, almost-empty and mailbox-full flags on side B. On the rising edge of the reset pin itself, not on any clock, the block captures a 2-bit offset-select code. The surrounding FIFO later maps this code to its almost-full and almost-empty thresholds.

After release, each domain reports on its own done output whether it saw enough edges. A status bit records any release that came too early. That bit stays set until the next reset starts.

Top module: `dualclk_rst_init`

## Requirements
- R1: While `rstN` is low, `almostFullA` and `mailFullA` are 1 and `fullA` is 0. These values appear as soon as `rstN` falls, without waiting for a clock edge.
- R2: While `rstN` is low, `mailFullB` is 1 and `emptyB` and `almostEmptyB` are 0. These values also appear as soon as `rstN` falls.
- R3: Each domain passes reset through a two-stage synchronizer. From the third rising edge of its own clock after `rstN` falls, `doneA` (or `doneB`) is 0 for as long as reset stays low.
- R4: `doneA` becomes 1 on the third rising edge of `clkA` after `rstN` rises, if domain A counted at least four `clkA` edges with its synchronized reset low.
- R5: `doneB` becomes 1 on the third rising edge of `clkB` after `rstN` rises, if domain B counted at least four `clkB` edges with its synchronized reset low.
- R6: If either domain sees reset released after fewer than four counted edges, that domain's done output stays 0 and `resetBad` goes to 1.
- R7: `resetBad` stays set for as long as `rstN` stays high. It clears once both domains have seen a new reset, and it stays 0 after a complete reset.
- R8: On each rising edge of `rstN`, `offCode` takes the value present on `offSel` at that moment.
- R9: Changes on `offSel` have no effect on `offCode` at any time other than a rising edge of `rstN`.
- R10: Each per-domain edge counter saturates at four. A reset held for more than eight edges of a clock therefore still completes in that domain, with no wrap of the 3-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Write-side clock |
| clkB | input | 1 | Read-side clock, unrelated to clkA |
| rstN | input | 1 | Asynchronous active-low reset pin |
| offSel | input | 2 | Offset-select code, captured on the rising edge of rstN |
| doneA | output | 1 | Domain A finished a complete reset |
| doneB | output | 1 | Domain B finished a complete reset |
| resetBad | output | 1 | Sticky flag: last release came too early in some domain |
| offCode | output | 2 | Latched offset-select code |
| fullA | output | 1 | Full flag start value (side A) |
| almostFullA | output | 1 | Almost-full flag start value (side A) |
| mailFullA | output | 1 | Side-A mailbox-full flag start value |
| emptyB | output | 1 | Empty flag start value (side B) |
| almostEmptyB | output | 1 | Almost-empty flag start value (side B) |
| mailFullB | output | 1 | Side-B mailbox-full flag start value |

## Verification
A corrupted edge count shows up three edges after release. It appears either as a done output that stays low after a long reset, or as a done output that rises after a short reset with `resetBad` left clear. A synchronizer or edge-detect fault shifts or suppresses the clearing of done and `resetBad` during reset. This is visible within a few cycles of the affected clock. A capture fault in the offset latch shows on `offCode` immediately after the reset edge, or whenever `offSel` moves while reset is high.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Strobes from a domain controller to its datapath, valid for one edge.
  typedef struct packed {
    logic startCnt;   // reset newly seen: clear status, count this edge
    logic stepCnt;    // reset still seen: advance the saturating counter
    logic relGood;    // release seen with a full count
    logic relBad;     // release seen with a short count
  } seqStrobe_t;

  localparam int NUM_DOM = 2;
  localparam int FLAG_W  = 3;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic syncQ
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stageQ;
      always_ff @(posedge clk) stageQ <= rstN;
      assign syncQ = stageQ;
    end else begin : g_chain
      logic [STAGES-1:0] stageQ;
      always_ff @(posedge clk) stageQ <= {stageQ[STAGES-2:0], rstN};
      assign syncQ = stageQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int EDGE_TARGET = 4,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             syncQ,
  input  logic [CNT_W-1:0] cnt,
  output seqStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] TARGET_V = CNT_W'(EDGE_TARGET);

  logic prevQ;
  logic atTarget;

  always_ff @(posedge clk) prevQ <= syncQ;

  assign atTarget = (cnt == TARGET_V);

  always_comb begin
    strobe          = '0;
    strobe.startCnt = !syncQ && prevQ;
    strobe.stepCnt  = !syncQ && !prevQ && !atTarget;
    strobe.relGood  = syncQ && !prevQ && atTarget;
    strobe.relBad   = syncQ && !prevQ && !atTarget;
  end

endmodule

// File: rtl/rst_seq_data.sv
module rst_seq_data
  import rst_seq_pkg::*;
#(
  parameter int                CNT_W     = 3,
  parameter logic [FLAG_W-1:0] FLAG_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic [CNT_W-1:0]  cnt,
  output logic              doneQ,
  output logic              badQ,
  output logic [FLAG_W-1:0] flagQ
);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (strobe.startCnt)      cntQ <= CNT_W'(1);
    else if (strobe.stepCnt)  cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (strobe.startCnt) begin
      doneQ <= 1'b0;
      badQ  <= 1'b0;
    end else if (strobe.relGood) begin
      doneQ <= 1'b1;
    end else if (strobe.relBad) begin
      badQ  <= 1'b1;
    end
  end

  // Start values are forced straight from the pin, ahead of any clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= FLAG_INIT;
  end

  assign cnt = cntQ;

endmodule

// File: rtl/dualclk_rst_init.sv
module dualclk_rst_init
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_TARGET = 4,
  parameter int OFF_W       = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic [OFF_W-1:0] offSel,
  output logic             doneA,
  output logic             doneB,
  output logic             resetBad,
  output logic [OFF_W-1:0] offCode,
  output logic             fullA,
  output logic             almostFullA,
  output logic             mailFullA,
  output logic             emptyB,
  output logic             almostEmptyB,
  output logic             mailFullB
);

  localparam int CNT_W = $clog2(EDGE_TARGET + 1);
  // Flag start values, packed {mailbox, almost, full/empty}.
  localparam logic [FLAG_W-1:0] INIT_A = 3'b110;
  localparam logic [FLAG_W-1:0] INIT_B = 3'b100;

  logic [NUM_DOM-1:0]  domClk;
  logic [NUM_DOM-1:0]  domDone;
  logic [NUM_DOM-1:0]  domBad;
  logic [FLAG_W-1:0]   domFlag [NUM_DOM];
  logic [OFF_W-1:0]    offCodeQ;

  assign domClk = {clkB, clkA};

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      logic             syncQ;
      logic [CNT_W-1:0] cnt;
      seqStrobe_t       strobe;

      rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (domClk[d]),
        .rstN  (rstN),
        .syncQ (syncQ)
      );

      rst_seq_ctrl #(.EDGE_TARGET(EDGE_TARGET), .CNT_W(CNT_W)) u_ctrl (
        .clk    (domClk[d]),
        .syncQ  (syncQ),
        .cnt    (cnt),
        .strobe (strobe)
      );

      rst_seq_data #(
        .CNT_W     (CNT_W),
        .FLAG_INIT ((d == 0) ? INIT_A : INIT_B)
      ) u_data (
        .clk    (domClk[d]),
        .rstN   (rstN),
        .strobe (strobe),
        .cnt    (cnt),
        .doneQ  (domDone[d]),
        .badQ   (domBad[d]),
        .flagQ  (domFlag[d])
      );
    end
  endgenerate

  // Offset code is sampled by the release edge of the reset pin itself.
  always_ff @(posedge rstN) offCodeQ <= offSel;

  assign doneA        = domDone[0];
  assign doneB        = domDone[1];
  assign resetBad     = |domBad;
  assign offCode      = offCodeQ;
  assign fullA        = domFlag[0][0];
  assign almostFullA  = domFlag[0][1];
  assign mailFullA    = domFlag[0][2];
  assign emptyB       = domFlag[1][0];
  assign almostEmptyB = domFlag[1][1];
  assign mailFullB    = domFlag[1][2];

endmodule

// File: rtl/dualclk_rst_init_chk.sv
module dualclk_rst_init_chk #(
  parameter int OFF_W = 2
) (
  input logic             clkA,
  input logic             clkB,
  input logic             rstN,
  input logic [OFF_W-1:0] offCode,
  input logic             doneA,
  input logic             doneB,
  input logic             resetBad,
  input logic             fullA,
  input logic             almostFullA,
  input logic             mailFullA,
  input logic             emptyB,
  input logic             almostEmptyB,
  input logic             mailFullB
);

  logic armed = 1'b0;
  always_ff @(negedge rstN) armed <= 1'b1;

  // R1
  p_flags_a_r1: assert property (@(posedge clkA) disable iff (!armed)
    !rstN |-> (almostFullA && mailFullA && !fullA));

  // R2
  p_flags_b_r2: assert property (@(posedge clkB) disable iff (!armed)
    !rstN |-> (mailFullB && !emptyB && !almostEmptyB));

  // R3
  p_done_low_a_r3: assert property (@(posedge clkA) disable iff (!armed)
    (!rstN && $past(!rstN) && $past(!rstN, 2) && $past(!rstN, 3)) |-> !doneA);

  p_done_low_b_r3: assert property (@(posedge clkB) disable iff (!armed)
    (!rstN && $past(!rstN) && $past(!rstN, 2) && $past(!rstN, 3)) |-> !doneB);

  // R6: a complete reset in both domains leaves no early-release record
  p_bad_excl_r6: assert property (@(posedge clkA) disable iff (!armed)
    (doneA && doneB) |-> !resetBad);

  // R4
  p_done_after_release_r4: assert property (@(posedge clkA) disable iff (!armed)
    $rose(doneA) |-> rstN);

  // R9
  p_offcode_stable_r9: assert property (@(posedge clkA) disable iff (!armed)
    (rstN && $past(rstN)) |-> $stable(offCode));

endmodule

bind dualclk_rst_init dualclk_rst_init_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/dualclk_rst_init_bench.sv
module dualclk_rst_init_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int CLKB_PERIOD = 38;
  localparam int WATCHDOG    = 100000;

  logic       clkA = 1'b0;
  logic       clkB = 1'b0;
  logic       rstN = 1'b1;
  logic [1:0] offSel = 2'b00;
  logic       doneA, doneB, resetBad;
  logic [1:0] offCode;
  logic       fullA, almostFullA, mailFullA, emptyB, almostEmptyB, mailFullB;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  typedef struct {
    string req;
    string sig;
    int    exp;
  } sbItem_t;

  sbItem_t sbQ[$];
  event    chkEv;

  always #(CLK_PERIOD / 2) clkA = ~clkA;
  always #(CLKB_PERIOD / 2) clkB = ~clkB;

  dualclk_rst_init u_dualclk_rst_init (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .offSel(offSel),
    .doneA(doneA), .doneB(doneB), .resetBad(resetBad), .offCode(offCode),
    .fullA(fullA), .almostFullA(almostFullA), .mailFullA(mailFullA),
    .emptyB(emptyB), .almostEmptyB(almostEmptyB), .mailFullB(mailFullB)
  );

  function automatic int sample(string sig);
    case (sig)
      "doneA":        return int'(doneA);
      "doneB":        return int'(doneB);
      "resetBad":     return int'(resetBad);
      "offCode":      return int'(offCode);
      "fullA":        return int'(fullA);
      "almostFullA":  return int'(almostFullA);
      "mailFullA":    return int'(mailFullA);
      "emptyB":       return int'(emptyB);
      "almostEmptyB": return int'(almostEmptyB);
      "mailFullB":    return int'(mailFullB);
      default:        return -1;
    endcase
  endfunction

  // Monitor: pops expected items and compares with the ports.
  initial begin
    forever begin
      @(chkEv);
      while (sbQ.size() > 0) begin
        sbItem_t it;
        int act;
        it  = sbQ.pop_front();
        act = sample(it.sig);
        compared++;
        if (act != it.exp) begin
          mismatched++;
          $display("FAIL %s %s: actual %0d expected %0d", it.req, it.sig, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, string sig, int exp);
    sbItem_t it;
    it.req = req;
    it.sig = sig;
    it.exp = exp;
    sbQ.push_back(it);
  endtask

  task automatic flush();
    ->chkEv;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Let both synchronizers fill with the released level first.
    #(CLKB_PERIOD * 5 + 3);

    // ---- Complete reset, long enough to exceed eight edges of each clock
    offSel = 2'b10;
    rstN   = 1'b0;
    #1;
    expect_val("R1", "almostFullA", 1);
    expect_val("R1", "mailFullA", 1);
    expect_val("R1", "fullA", 0);
    expect_val("R2", "mailFullB", 1);
    expect_val("R2", "emptyB", 0);
    expect_val("R2", "almostEmptyB", 0);
    flush();
    #200;
    expect_val("R3", "doneA", 0);
    expect_val("R3", "doneB", 0);
    expect_val("R7", "resetBad", 0);
    flush();
    #100;
    offSel = 2'b01;
    #100;
    rstN = 1'b1;
    #1;
    expect_val("R8", "offCode", 1);
    flush();
    #5;
    offSel = 2'b11;
    #(CLKB_PERIOD * 6);
    expect_val("R4", "doneA", 1);
    expect_val("R5 R10", "doneB", 1);
    expect_val("R7", "resetBad", 0);
    expect_val("R9", "offCode", 1);
    flush();

    // ---- Early release in domain A (two clkA edges only)
    @(posedge clkA);
    #2;
    rstN = 1'b0;
    #18;
    offSel = 2'b10;
    rstN   = 1'b1;
    #1;
    expect_val("R8", "offCode", 2);
    flush();
    #(CLKB_PERIOD * 6);
    expect_val("R6", "doneA", 0);
    expect_val("R6", "resetBad", 1);
    flush();
    offSel = 2'b00;
    #2000;
    expect_val("R7", "resetBad", 1);
    expect_val("R9", "offCode", 2);
    flush();

    // ---- A complete, B short: B sees two edges only
    @(posedge clkB);
    #2;
    rstN = 1'b0;
    #80;
    rstN = 1'b1;
    #300;
    expect_val("R4", "doneA", 1);
    expect_val("R6", "doneB", 0);
    expect_val("R6", "resetBad", 1);
    expect_val("R8", "offCode", 0);
    flush();

    // ---- Another complete reset clears the sticky bit
    offSel = 2'b11;
    rstN   = 1'b0;
    #250;
    expect_val("R7", "resetBad", 0);
    expect_val("R3", "doneA", 0);
    flush();
    #200;
    rstN = 1'b1;
    #(CLKB_PERIOD * 6);
    expect_val("R4", "doneA", 1);
    expect_val("R5", "doneB", 1);
    expect_val("R7", "resetBad", 0);
    expect_val("R8", "offCode", 3);
    flush();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule